// File: doc/BRIEF.md
# Self-Starting One-Hot Shift Ring

This block is a four-stage ring of rising-edge D flip-flops that carries a single marker bit. The ring is not closed by feeding the last stage back into the first. Feedback logic watches all stages and puts a 1 into the first stage only when the whole ring is empty. The visible cycle therefore has five states: the empty state and four one-hot states. The same rule makes the ring recover by itself from any starting pattern. No 1 enters while any stage holds a 1, so any corrupt pattern drains out of the last stage and the normal cycle then starts again.

Each advance is either automatic or manual. In automatic mode the synchronous step enable moves the ring on every cycle in which it is high. In manual mode a pushbutton level, already free of bounce, passes through a two-flop synchronizer and a two-state edge detector. That path makes a one-cycle step pulse for each press. The ring shows each stage's true value and its complement, and the complement drives active-low indicators. A synchronous preset port loads any pattern into the ring, so every starting state can be reached.

The edge detector has two states. `BTN_RELEASED` moves to `BTN_HELD` when the synchronized button reads 1, and that transition makes the step pulse. `BTN_HELD` moves back to `BTN_RELEASED` when the synchronized button reads 0.

Top module: `onehot_ring`

## Requirements
- R1: While `rst_n` is low, every bit of `stage_q` is 0 and every bit of `stage_n` is 1. Bit 0 of each bus is stage a, bit 1 is stage b, bit 2 is stage c and bit 3 is stage d.
- R2: `stage_n` is always the bitwise complement of `stage_q`.
- R3: An advance taken while all stages hold 0 sets stage a to 1 and leaves the other stages at 0, so `stage_q` becomes 4'b0001.
- R4: An advance taken while any stage holds 1 loads 0 into stage a. Every other stage loads the stage before it, so the next `stage_q` is `{stage_q[2:0],1'b0}`.
- R5: In a cycle with no advance and no preset, `stage_q` keeps its value.
- R6: After reset, five advances visit the states a-b-c-d = 0000, 1000, 0100, 0010, 0001 and then 0000 again. On `stage_q` these are 0, 1, 2, 4, 8 and 0.
- R7: Start from any of the 16 preset patterns. Within at most four advances the ring holds at most one 1. Within at most five advances it is in one of the five legal states.
- R8: With `mode_manual` = 1, a rising edge of `btn_level` gives exactly one advance. The ring changes at the third rising clock edge after the level goes high. Holding the button gives no further advance.
- R9: With `mode_manual` = 1, `step_en` is ignored. With `mode_manual` = 0, `btn_level` is ignored and each cycle with `step_en` = 1 is one advance.
- R10: When `preset_load` is high, the next `stage_q` equals `preset_val`, even if an advance falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_manual | input | 1 | 1 selects the button path as the step source, 0 selects `step_en` |
| step_en | input | 1 | Synchronous advance request used in automatic mode |
| btn_level | input | 1 | Button level with bounce already removed, asynchronous to `clk` |
| preset_load | input | 1 | Synchronous load of `preset_val` into the stages |
| preset_val | input | 4 | Pattern to load; bit 0 is stage a |
| stage_q | output | 4 | True stage values; bit 0 is stage a |
| stage_n | output | 4 | Complemented stage values for active-low indicators |

## Verification
A preset load and an advance can fall in the same clock cycle. The bench sets `preset_load` together with `step_en`, and also times a preset to land in the cycle where the button pulse is high. In both cases it checks that the loaded pattern appears unchanged, with no shift applied on top of it. A second overlap appears when the ring is empty. There the injection into stage a and the shift of the other stages happen in the same advance. The bench judges this by the exact 0001 value that follows an empty ring, including empty states reached by draining a preset pattern.

// File: rtl/ring_pkg.sv
package ring_pkg;

    // Number of flip-flop stages in the ring and synchronizer depth.
    localparam int unsigned RING_STAGES_DEF = 4;
    localparam int unsigned SYNC_DEPTH_DEF  = 2;

    // Edge detector for the synchronized button level.
    typedef enum logic {
        BTN_RELEASED = 1'b0,
        BTN_HELD     = 1'b1
    } btn_state_t;

endpackage

// File: rtl/ring_btn_sync.sv
module ring_btn_sync
    import ring_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_level,
    output logic btn_pulse
);

    localparam int unsigned SYNC_MSB = SYNC_STAGES - 1;

    logic [SYNC_MSB:0] sync_q;
    logic              btn_sync;
    btn_state_t        state_q;
    btn_state_t        state_d;

    // Synchronizer chain: the raw level enters at bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_MSB-1:0], btn_level};
        end
    end

    assign btn_sync = sync_q[SYNC_MSB];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BTN_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output.
    always_comb begin
        state_d   = state_q;
        btn_pulse = 1'b0;
        unique case (state_q)
            BTN_RELEASED: begin
                if (btn_sync) begin
                    state_d   = BTN_HELD;
                    btn_pulse = 1'b1;
                end
            end
            BTN_HELD: begin
                if (!btn_sync) begin
                    state_d = BTN_RELEASED;
                end
            end
            default: begin
                state_d = BTN_RELEASED;
            end
        endcase
    end

endmodule

// File: rtl/ring_feedback.sv
module ring_feedback #(
    parameter int unsigned NUM_STAGES = 4
) (
    input  logic [NUM_STAGES-1:0] stage_q,
    output logic                  inject
);

    // A new marker enters only when the ring is completely empty.
    assign inject = ~(|stage_q);

endmodule

// File: rtl/ring_stages.sv
module ring_stages #(
    parameter int unsigned NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [NUM_STAGES-1:0] load_val,
    input  logic                  shift,
    input  logic                  inject,
    output logic [NUM_STAGES-1:0] stage_q
);

    logic [NUM_STAGES-1:0] stage_d;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign stage_d[i] = inject;
        end else begin : g_body
            assign stage_d[i] = stage_q[i-1];
        end

        // Preset has priority over an advance in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[i] <= 1'b0;
            end else if (load) begin
                stage_q[i] <= load_val[i];
            end else if (shift) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

endmodule

// File: rtl/onehot_ring.sv
module onehot_ring
    import ring_pkg::*;
#(
    parameter int unsigned NUM_STAGES  = RING_STAGES_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_manual,
    input  logic                  step_en,
    input  logic                  btn_level,
    input  logic                  preset_load,
    input  logic [NUM_STAGES-1:0] preset_val,
    output logic [NUM_STAGES-1:0] stage_q,
    output logic [NUM_STAGES-1:0] stage_n
);

    logic btn_pulse;
    logic step_go;
    logic inject;

    ring_btn_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_btn (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_level (btn_level),
        .btn_pulse (btn_pulse)
    );

    // Choose the step source.
    assign step_go = mode_manual ? btn_pulse : step_en;

    ring_feedback #(
        .NUM_STAGES (NUM_STAGES)
    ) i_fb (
        .stage_q (stage_q),
        .inject  (inject)
    );

    ring_stages #(
        .NUM_STAGES (NUM_STAGES)
    ) i_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (preset_load),
        .load_val (preset_val),
        .shift    (step_go),
        .inject   (inject),
        .stage_q  (stage_q)
    );

    assign stage_n = ~stage_q;

endmodule

// File: rtl/onehot_ring_chk.sv
module onehot_ring_chk #(
    parameter int unsigned NUM_STAGES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  preset_load,
    input logic [NUM_STAGES-1:0] preset_val,
    input logic                  step_go,
    input logic                  btn_pulse,
    input logic [NUM_STAGES-1:0] stage_q
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_empty_R1: assert (stage_q == '0)
                else $error("R1 stages not empty in reset");
        end
    end

    assert_inject_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_load && step_go && stage_q == '0) |=> (stage_q == {{(NUM_STAGES-1){1'b0}}, 1'b1}));

    assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_load && step_go && stage_q != '0)
        |=> (stage_q == {$past(stage_q[NUM_STAGES-2:0]), 1'b0}));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_load && !step_go) |=> $stable(stage_q));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        btn_pulse |=> !btn_pulse);

    assert_preset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        preset_load |=> (stage_q == $past(preset_val)));

endmodule

bind onehot_ring onehot_ring_chk #(
    .NUM_STAGES (NUM_STAGES)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .preset_load (preset_load),
    .preset_val  (preset_val),
    .step_go     (step_go),
    .btn_pulse   (btn_pulse),
    .stage_q     (stage_q)
);

// File: tb/test_onehot_ring.sv
module test_onehot_ring;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_manual;
    logic         step_en;
    logic         btn_level;
    logic         preset_load;
    logic [N-1:0] preset_val;
    logic [N-1:0] stage_q;
    logic [N-1:0] stage_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    onehot_ring i_onehot_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_manual (mode_manual),
        .step_en     (step_en),
        .btn_level   (btn_level),
        .preset_load (preset_load),
        .preset_val  (preset_val),
        .stage_q     (stage_q),
        .stage_n     (stage_n)
    );

    // Reference step rule built from R3 and R4.
    function automatic logic [N-1:0] model_next(input logic [N-1:0] s);
        return (s == '0) ? {{(N-1){1'b0}}, 1'b1} : {s[N-2:0], 1'b0};
    endfunction

    task automatic check_ring(input string req, input logic [N-1:0] exp);
        n_checks++;
        if (stage_q !== exp) begin
            n_fail++;
            $display("FAIL %s stage_q actual=%b expected=%b", req, stage_q, exp);
        end
        n_checks++;
        if (stage_n !== ~exp) begin
            n_fail++;
            $display("FAIL R2 (%s) stage_n actual=%b expected=%b", req, stage_n, ~exp);
        end
    endtask

    task automatic auto_step;
        @(negedge clk) step_en = 1'b1;
        @(negedge clk) step_en = 1'b0;
    endtask

    task automatic preset(input logic [N-1:0] v);
        @(negedge clk);
        preset_load = 1'b1;
        preset_val  = v;
        @(negedge clk);
        preset_load = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        mode_manual = 1'b0; step_en = 1'b0; btn_level = 1'b0;
        preset_load = 1'b0; preset_val = '0;
        repeat (3) @(negedge clk);
        check_ring("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sequence;
        logic [N-1:0] exp_seq [6];
        exp_seq[0] = 4'b0000; exp_seq[1] = 4'b0001; exp_seq[2] = 4'b0010;
        exp_seq[3] = 4'b0100; exp_seq[4] = 4'b1000; exp_seq[5] = 4'b0000;
        check_ring("R6", exp_seq[0]);
        for (int k = 1; k < 6; k++) begin
            auto_step();
            check_ring(k == 1 ? "R3" : "R6", exp_seq[k]);
        end
    endtask

    task automatic t_hold;
        preset(4'b0100);
        repeat (5) @(negedge clk);
        check_ring("R5", 4'b0100);
        btn_level = 1'b1;
        repeat (5) @(negedge clk);
        check_ring("R9 auto ignores button", 4'b0100);
        btn_level = 1'b0;
        repeat (4) @(negedge clk);
        auto_step();
        check_ring("R4", 4'b1000);
    endtask

    task automatic t_recovery;
        for (int p = 0; p < 16; p++) begin
            logic [N-1:0] exp;
            preset(p[N-1:0]);
            exp = p[N-1:0];
            check_ring("R10", exp);
            for (int k = 1; k <= 5; k++) begin
                auto_step();
                exp = model_next(exp);
                check_ring("R7", exp);
                if (k == 4) begin
                    n_checks++;
                    if ($countones(stage_q) > 1) begin
                        n_fail++;
                        $display("FAIL R7 ones after 4 actual=%0d expected<=1", $countones(stage_q));
                    end
                end
            end
        end
    endtask

    task automatic t_manual;
        preset(4'b0000);
        mode_manual = 1'b1;
        step_en = 1'b1;
        repeat (4) @(negedge clk);
        check_ring("R9 manual ignores step_en", 4'b0000);
        step_en = 1'b0;
        btn_level = 1'b1;
        repeat (2) @(negedge clk);
        check_ring("R8 no change before third edge", 4'b0000);
        @(negedge clk);
        check_ring("R8 one advance", 4'b0001);
        repeat (6) @(negedge clk);
        check_ring("R8 held gives no repeat", 4'b0001);
        btn_level = 1'b0;
        repeat (4) @(negedge clk);
        check_ring("R8 release no advance", 4'b0001);
        btn_level = 1'b1;
        repeat (3) @(negedge clk);
        check_ring("R8 second press", 4'b0010);
        btn_level = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_collision;
        // Preset and automatic advance in the same cycle.
        mode_manual = 1'b0;
        @(negedge clk);
        preset_load = 1'b1; preset_val = 4'b0110; step_en = 1'b1;
        @(negedge clk);
        preset_load = 1'b0; step_en = 1'b0;
        check_ring("R10 preset beats step_en", 4'b0110);
        // Preset lands in the cycle where the button pulse is high.
        mode_manual = 1'b1;
        btn_level = 1'b1;
        repeat (2) @(negedge clk);
        preset_load = 1'b1; preset_val = 4'b1001;
        @(negedge clk);
        preset_load = 1'b0;
        check_ring("R10 preset beats button", 4'b1001);
        repeat (4) @(negedge clk);
        check_ring("R8 pulse consumed", 4'b1001);
        btn_level = 1'b0;
        mode_manual = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sequence();
        t_hold();
        t_recovery();
        t_manual();
        t_collision();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_ring("R1 reset again", '0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule